// File: doc/BRIEF.md
# Iterative Integer Multiplier with Selectable Product Half

This block multiplies two 32-bit operands and returns one 32-bit word of the 64-bit product. A 2-bit operation code chooses the word and how the operands are read. The low word needs no signedness rule. For the high word, the operands can be read as both signed, as signed-by-unsigned, or as both unsigned.

A request is offered by raising `start` together with the operands and the code. It is taken on any clock edge where the unit is not busy. The unit strips the signs down to unsigned magnitudes and accumulates the product a few multiplier bits per cycle using shift-and-add. It then restores the sign of the full 64-bit product and keeps the requested half. The result is registered and `done` pulses for one cycle. The result word then holds its value until the next accepted request finishes.

Top module: `rv_mul_unit`

## Requirements
- R1: Operation code 2'b00 returns bits 31:0 of the product and wraps silently, so 0x7FFFFFFF times 2 gives 0xFFFFFFFE.
- R2: Operation code 2'b01 reads both operands as two's complement and returns bits 63:32. For example, 0x7FFFFFFF times 2 gives 0x00000000, and 0xFFFFFFFF times 0xFFFFFFFF gives 0x00000000.
- R3: Operation code 2'b10 reads `src_a` as signed and `src_b` as unsigned and returns bits 63:32. For example, 0xFFFFFFFE times 3 gives 0xFFFFFFFF, and 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFF.
- R4: Operation code 2'b11 reads both operands as unsigned and returns bits 63:32. For example, 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE.
- R5: If either operand is zero, the result is 0 for every operation code.
- R6: `done` rises exactly 32/STEP_BITS clock edges after the edge that accepts `start` (8 with the defaults) and stays high for one cycle only.
- R7: `start` is accepted only while `busy` is low. A `start` seen while busy is ignored, so each accepted request produces exactly one `done`.
- R8: After `done`, `result` keeps its value and `done` stays low until the next accepted request completes.
- R9: After reset, `busy` and `done` are low and `result` is 0.
- R10: The most negative operand is handled. For 0x80000000 times 0x80000000, code 2'b01 gives 0x40000000, code 2'b10 gives 0xC0000000 and code 2'b11 gives 0x40000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe; taken when `busy` is low |
| op | input | 2 | 00 low word, 01 high signed×signed, 10 high signed×unsigned, 11 high unsigned×unsigned |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| busy | output | 1 | High while a product is being accumulated |
| done | output | 1 | One-cycle strobe when `result` is updated |
| result | output | 32 | Selected 32-bit word of the product |

## Verification
The bench goes after the sign corners:
- minus one times minus one, which would give a high word of 0xFFFFFFFF if the sign were not restored over the full 64 bits;
- the mixed-sign operation with an all-ones `src_b`, which a design that sign-extended the second operand would turn into 0;
- the most negative operand, whose magnitude does not fit a signed 32-bit word.

Random operands across all four codes catch a wrong row weight or a lost carry in the shift-add loop. Requests offered while busy would show up as extra `done` strobes or as a corrupted first result. Each strobe is matched against the cycle it is due, so an off-by-one iteration count cannot hide. After each strobe the held result is watched for drift.

// File: rtl/rv_mul_pkg.sv
package rv_mul_pkg;

  typedef enum logic [1:0] {
    OP_LO    = 2'b00,
    OP_HI_SS = 2'b01,
    OP_HI_SU = 2'b10,
    OP_HI_UU = 2'b11
  } mul_op_e;

  // first operand read as signed
  function automatic logic a_is_signed(mul_op_e op);
    return (op == OP_HI_SS) || (op == OP_HI_SU);
  endfunction

  // second operand read as signed
  function automatic logic b_is_signed(mul_op_e op);
    return (op == OP_HI_SS);
  endfunction

  function automatic logic wants_high(mul_op_e op);
    return (op != OP_LO);
  endfunction

endpackage

// File: rtl/rv_mul_reset_sync.sv
module rv_mul_reset_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/rv_mul_operand_prep.sv
module rv_mul_operand_prep
  import rv_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  mul_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   mag_a,
  output logic [W-1:0]   mag_b,
  output logic           neg
);

  logic a_neg, b_neg;

  // sign (or zero) extension to W+1 bits reduces to a sign flag plus a
  // W-bit magnitude; the most negative value maps onto itself unsigned
  always_comb begin
    a_neg = a_is_signed(op) & a[W-1];
    b_neg = b_is_signed(op) & b[W-1];
    mag_a = a_neg ? (~a + W'(1)) : a;
    mag_b = b_neg ? (~b + W'(1)) : b;
    neg   = a_neg ^ b_neg;
  end

endmodule

// File: rtl/rv_mul_shift_add.sv
module rv_mul_shift_add #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  output logic           busy,
  output logic           last_step,
  output logic [2*W-1:0] acc_next
);

  localparam int ITER = W / STEP;
  localparam int CW   = $clog2(ITER + 1);
  localparam int PW   = 2 * W;

  logic [PW-1:0] mcand_q, mcand_d;
  logic [W-1:0]  mplier_q, mplier_d;
  logic [PW-1:0] acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          en;

  logic [PW-1:0] row [STEP];
  logic [PW-1:0] psum;

  // one partial-product row per multiplier bit handled this cycle
  for (genvar j = 0; j < STEP; j++) begin : g_row
    assign row[j] = mplier_q[j] ? (mcand_q << j) : '0;
  end

  always_comb begin
    psum = '0;
    for (int j = 0; j < STEP; j++) psum = psum + row[j];
  end

  assign last_step = busy_q && (cnt_q == CW'(1));
  assign acc_next  = acc_q + psum;

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    en       = 1'b0;
    if (load && !busy_q) begin
      en       = 1'b1;
      mcand_d  = {{W{1'b0}}, mag_a};
      mplier_d = mag_b;
      acc_d    = '0;
      cnt_d    = CW'(ITER);
      busy_d   = 1'b1;
    end else if (busy_q) begin
      en       = 1'b1;
      mcand_d  = mcand_q << STEP;
      mplier_d = mplier_q >> STEP;
      acc_d    = acc_next;
      cnt_d    = cnt_q - CW'(1);
      busy_d   = (cnt_q != CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
    end else if (en) begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
      cnt_q    <= cnt_d;
      busy_q   <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/rv_mul_result_select.sv
module rv_mul_result_select
  import rv_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  mul_op_e        op,
  input  logic [2*W-1:0] mag_prod,
  input  logic           neg,
  output logic [W-1:0]   res
);

  logic [2*W-1:0] prod;

  always_comb begin
    prod = neg ? (~mag_prod + (2*W)'(1)) : mag_prod;
    res  = wants_high(op) ? prod[2*W-1:W] : prod[W-1:0];
  end

endmodule

// File: rtl/rv_mul_unit.sv
module rv_mul_unit
  import rv_mul_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int STEP_BITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);

  logic            rst_core_n;
  mul_op_e         op_in, op_q, op_d;
  logic [XLEN-1:0] mag_a, mag_b, sel_res;
  logic            neg_in, neg_q, neg_d;
  logic            core_busy, last_step, accept;
  logic [2*XLEN-1:0] acc_next;
  logic [XLEN-1:0] result_q, result_d;
  logic            done_q, done_d;
  logic            en_ctx, en_res;

  assign op_in  = mul_op_e'(op);
  assign accept = start && !core_busy;

  rv_mul_reset_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  rv_mul_operand_prep #(.W(XLEN)) u_prep (
    .op    (op_in),
    .a     (src_a),
    .b     (src_b),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .neg   (neg_in)
  );

  rv_mul_shift_add #(.W(XLEN), .STEP(STEP_BITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (accept),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .busy      (core_busy),
    .last_step (last_step),
    .acc_next  (acc_next)
  );

  rv_mul_result_select #(.W(XLEN)) u_sel (
    .op       (op_q),
    .mag_prod (acc_next),
    .neg      (neg_q),
    .res      (sel_res)
  );

  always_comb begin
    en_ctx   = accept;
    op_d     = op_in;
    neg_d    = neg_in;
    en_res   = last_step;
    result_d = sel_res;
    done_d   = last_step;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      op_q  <= OP_LO;
      neg_q <= 1'b0;
    end else if (en_ctx) begin
      op_q  <= op_d;
      neg_q <= neg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) result_q <= '0;
    else if (en_res) result_q <= result_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign busy   = core_busy;
  assign done   = done_q;
  assign result = result_q;

endmodule

module rv_mul_unit_chk #(
  parameter int XLEN      = 32,
  parameter int STEP_BITS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result
);

  localparam int ITER = XLEN / STEP_BITS;
  localparam int LW   = $clog2(ITER + 2);

  logic [LW-1:0] lat_q;
  logic          zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      zero_q <= 1'b0;
    end else if (start && !busy) begin
      lat_q  <= '0;
      zero_q <= (src_a == '0) || (src_b == '0);
    end else if (busy) begin
      lat_q  <= lat_q + LW'(1);
    end
  end

  // R6: done only after exactly ITER busy cycles
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(ITER)));

  // R6: done is a single-cycle strobe
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: an idle start is taken
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7: done never overlaps busy
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: result holds between strobes
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R5: zero operand gives zero result
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_q) |-> (result == '0));

endmodule

bind rv_mul_unit rv_mul_unit_chk #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .src_a  (src_a),
  .src_b  (src_b),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/rv_mul_unit_tb.sv
module rv_mul_unit_tb;

  localparam int ITER = 32 / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [31:0] src_a, src_b;
  logic        busy, done;
  logic [31:0] result;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] last_res = '0;

  logic [31:0] q_res[$];
  int          q_due[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rv_mul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [1:0] o, logic [31:0] a, logic [31:0] b);
    logic [63:0] ea, eb, p;
    ea = (o == 2'b01 || o == 2'b10) ? {{32{a[31]}}, a} : {32'b0, a};
    eb = (o == 2'b01) ? {{32{b[31]}}, b} : {32'b0, b};
    p  = ea * eb;
    return (o == 2'b00) ? p[31:0] : p[63:32];
  endfunction

  // driver: offers one request and records what must come back
  task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] exp, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    q_res.push_back(exp);
    q_due.push_back(cyc + 1 + ITER);
    q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (q_res.size() > 0) @(negedge clk);
  endtask

  // monitor: pops and compares
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_res.size() == 0) begin
        chk(1'b0, "R7 unexpected done", result, last_res);
      end else begin
        logic [31:0] e;
        int d;
        string t;
        e = q_res.pop_front();
        d = q_due.pop_front();
        t = q_tag.pop_front();
        chk(result === e, t, result, e);
        chk(cyc == d, "R6 done cycle", 32'(cyc), 32'(d));
        last_res = e;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", n_chk, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(!busy && !done, "R9 busy/done after reset", {30'b0, busy, done}, 32'h0);
    chk(result === 32'h0, "R9 result after reset", result, 32'h0);

    issue(2'b00, 32'h7FFF_FFFF, 32'd2, 32'hFFFF_FFFE, "R1 low word wrap");
    issue(2'b00, 32'd7, 32'd8, 32'd56, "R1 small product");
    issue(2'b01, 32'h7FFF_FFFF, 32'd2, 32'h0, "R2 signed high positive");
    issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R2 minus one squared");
    issue(2'b10, 32'hFFFF_FFFE, 32'd3, 32'hFFFF_FFFF, "R3 minus two by three");
    issue(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 second operand unsigned");
    issue(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R4 unsigned max squared");
    issue(2'b01, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, "R10 most negative signed");
    issue(2'b10, 32'h8000_0000, 32'h8000_0000, 32'hC000_0000, "R10 most negative mixed");
    issue(2'b11, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, "R10 most negative unsigned");
    for (int o = 0; o < 4; o++) begin
      issue(2'(o), 32'h0, 32'd42, 32'h0, "R5 zero first operand");
      issue(2'(o), 32'hFFFF_FFFF, 32'h0, 32'h0, "R5 zero second operand");
    end
    drain();

    // R8: held result, no further strobe
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(result === last_res && !done, "R8 result held", result, last_res);
    end

    // R7: start while busy is ignored
    issue(2'b11, 32'h1234_5678, 32'h9ABC_DEF0, model(2'b11, 32'h1234_5678, 32'h9ABC_DEF0), "R7 first of overlapped");
    start = 1'b1; op = 2'b00; src_a = 32'hDEAD_BEEF; src_b = 32'h5;
    repeat (3) @(negedge clk);
    start = 1'b0;
    drain();
    repeat (ITER + 4) @(negedge clk);
    chk(result === last_res, "R7 no second result", result, last_res);

    // random patterns, back to back
    for (int i = 0; i < 60; i++) begin
      logic [1:0] o;
      logic [31:0] a, b;
      o = 2'(i % 4);
      a = $urandom; b = $urandom;
      if (i % 7 == 3) a[31] = 1'b1;
      case (o)
        2'b00: issue(o, a, b, model(o, a, b), "R1 random");
        2'b01: issue(o, a, b, model(o, a, b), "R2 random");
        2'b10: issue(o, a, b, model(o, a, b), "R3 random");
        default: issue(o, a, b, model(o, a, b), "R4 random");
      endcase
    end
    drain();
    repeat (3) @(negedge clk);
    chk(!done && !busy, "R6 idle at end", {30'b0, busy, done}, 32'h0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule